// File: doc/BRIEF.md
# Pilot Tone Stereo/Dual Identifier

This block takes the shaped one-bit identification signal that a pilot-carrier demodulator produces and decides whether the broadcast carries the stereo tone (117.48 Hz) or the dual-sound tone (274.12 Hz). For each tone, a channel measures every full period of the square wave by counting prescaled clock ticks. A period counts as a hit when its length falls inside a narrow window around that tone. The window bounds are derived from the clock rate, the tone frequency and the half-width of the window. Each hit or miss moves a saturating up/down integrator. A flag with hysteresis then turns on only after steady detection and turns off only after steady loss.

Each channel has two state machines. The period meter waits in `MTR_ARM` until the first synchronised rising edge, then moves to `MTR_RUN`. In `MTR_RUN` every later rising edge closes one measured period. If no edge arrives in time, a timeout yields a miss. Reset or mute sends the meter back to `MTR_ARM`. The flag machine moves from `FLG_OFF` to `FLG_ON` when the integrator level reaches its set threshold. It moves from `FLG_ON` back to `FLG_OFF` when the level falls to its clear threshold, or at once on reset or mute. The top combines the two channel flags so that dual wins over stereo, and it drives active-low LED enables. The defaults assume a 10.008 MHz clock divided by 100. With them, a flag turns on about 0.82 s after a clean tone appears and turns off about 0.8 to 1.0 s after the tone is lost.

Top module: `pid_tone_ident`

## Requirements
- R1: Each interval between two consecutive synchronised rising edges of `tone_in` is measured in ticks. A tick is one clock when TICK_DIV=1, otherwise one pulse every TICK_DIV clocks. The interval is a hit for a tone when lo <= count <= hi, where lo = ceil(K/(f+h)), hi = floor(K/(f-h)), K = CLK_HZ*1000/TICK_DIV, and f and h are the tone frequency and the window half-width in millihertz. Any other count is a miss.
- R2: When no rising edge has arrived by the time the count reaches hi, the channel records a miss and restarts its count. While the input stays silent, this repeats about every hi ticks.
- R3: Each integrator level stays within 0 to MAX. A hit raises it by one, and a miss lowers it by one. At the limits the level saturates, and without a step it holds.
- R4: A flag turns on when its level reaches SET, turns off when its level falls to CLR, and otherwise keeps its previous value (hysteresis).
- R5: Dual takes priority: `stereo_flag` is low whenever `dual_flag` is high.
- R6: While `mute` is high, both levels are held at zero, both flags are low and the period meters are re-armed. After release, the first rising edge only starts a measurement and yields no step.
- R7: A synchronous `rst` clears the meters, integrators and flags in the same way as mute. The first edge after reset only arms the meter.
- R8: `led_stereo_n` and `led_dual_n` are the active-low complements of `stereo_flag` and `dual_flag`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| mute | input | 1 | Fast mute: clears and disables identification, active high |
| tone_in | input | 1 | Shaped identification square wave (asynchronous) |
| stereo_flag | output | 1 | Stereo tone identified (forced low when dual is set) |
| dual_flag | output | 1 | Dual tone identified |
| led_stereo_n | output | 1 | Stereo LED enable, active low |
| led_dual_n | output | 1 | Dual LED enable, active low |

## Verification
The bench builds the block with CLK_HZ=100000 and TICK_DIV=1, so one tick is one clock. This puts the stereo window at 844 to 859 cycles and the dual window at 364 to 366 cycles. It also uses MAX=15, SET=8 and CLR=3 for both integrators. Together these settings let single-cycle period changes probe both edges of each window. Complete set, clear, priority, silence-timeout and mute sequences each fit within a few tens of thousands of cycles instead of the seconds that the default settings need.

// File: rtl/pid_pkg.sv
package pid_pkg;

    typedef longint unsigned u64_t;

    // Period meter states
    typedef enum logic {
        MTR_ARM = 1'b0,
        MTR_RUN = 1'b1
    } mtr_state_t;

    // Identification flag states
    typedef enum logic {
        FLG_OFF = 1'b0,
        FLG_ON  = 1'b1
    } flg_state_t;

    localparam int CH_STEREO = 0;
    localparam int CH_DUAL   = 1;
    localparam int N_CH      = 2;

    function automatic u64_t ceil_div(u64_t n, u64_t d);
        return (n + d - 64'd1) / d;
    endfunction

endpackage

// File: rtl/pid_edge_sync.sv
module pid_edge_sync (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic din,
    output logic rise
);

    logic [2:0] sh;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sh <= '0;
        end else begin
            sh <= {sh[1:0], din};
        end
    end

    assign rise = sh[1] & ~sh[2];

    // R6: a cleared synchroniser reports no edge in the next cycle
    p_no_edge_after_clr_r6: assert property (@(posedge clk) disable iff (rst)
        clr |=> !rise);

endmodule

// File: rtl/pid_period_meter.sv
module pid_period_meter
    import pid_pkg::*;
#(
    parameter int LO = 844,
    parameter int HI = 859
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic tick,
    input  logic rise,
    output logic step_valid,
    output logic step_hit
);

    localparam int CNT_W = $clog2(HI + 1) + 1;
    localparam logic [CNT_W-1:0] LO_C = CNT_W'(LO);
    localparam logic [CNT_W-1:0] HI_C = CNT_W'(HI);
    localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);

    mtr_state_t       state, state_nx;
    logic [CNT_W-1:0] cnt;

    // State register
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            state <= MTR_ARM;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            MTR_ARM: state_nx = rise ? MTR_RUN : MTR_ARM;
            MTR_RUN: state_nx = MTR_RUN;
            default: state_nx = MTR_ARM;
        endcase
    end

    // Count and step outputs
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt        <= '0;
            step_valid <= 1'b0;
            step_hit   <= 1'b0;
        end else begin
            step_valid <= 1'b0;
            step_hit   <= 1'b0;
            unique case (state)
                MTR_ARM: begin
                    if (rise) begin
                        cnt <= ONE_C;
                    end
                end
                MTR_RUN: begin
                    if (rise) begin
                        step_valid <= 1'b1;
                        step_hit   <= (cnt >= LO_C) && (cnt <= HI_C);
                        cnt        <= ONE_C;
                    end else if (tick) begin
                        if (cnt == HI_C) begin
                            step_valid <= 1'b1;
                            step_hit   <= 1'b0;
                            cnt        <= ONE_C;
                        end else begin
                            cnt <= cnt + ONE_C;
                        end
                    end
                end
                default: cnt <= '0;
            endcase
        end
    end

    // R6: no step is reported in the cycle after a clear
    p_clr_silences_r6: assert property (@(posedge clk) disable iff (rst)
        clr |=> !step_valid);

    // R7: steps only come out of the running state
    p_step_from_run_r7: assert property (@(posedge clk) disable iff (rst)
        step_valid |-> $past(state) == MTR_RUN);

    // R2: a count reaching the upper limit without an edge is a miss
    p_timeout_miss_r2: assert property (@(posedge clk) disable iff (rst)
        (state == MTR_RUN && !clr && !rise && tick && cnt == HI_C)
        |=> (step_valid && !step_hit));

    // R1: the count never runs past the upper limit
    p_cnt_bound_r1: assert property (@(posedge clk) disable iff (rst)
        cnt <= HI_C);

endmodule

// File: rtl/pid_integrator.sv
module pid_integrator
    import pid_pkg::*;
#(
    parameter int MAX    = 127,
    parameter int SET_TH = 96,
    parameter int CLR_TH = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic step_valid,
    input  logic step_hit,
    output logic flag
);

    localparam int LVL_W = $clog2(MAX + 1);
    localparam logic [LVL_W-1:0] MAX_C = LVL_W'(MAX);
    localparam logic [LVL_W-1:0] SET_C = LVL_W'(SET_TH);
    localparam logic [LVL_W-1:0] CLR_C = LVL_W'(CLR_TH);

    flg_state_t       fstate, fstate_nx;
    logic [LVL_W-1:0] level, level_nx;

    always_comb begin
        level_nx = level;
        if (step_valid) begin
            if (step_hit) begin
                if (level != MAX_C) level_nx = level + 1'b1;
            end else if (level != '0) begin
                level_nx = level - 1'b1;
            end
        end
    end

    always_comb begin
        fstate_nx = fstate;
        unique case (fstate)
            FLG_OFF: fstate_nx = (level_nx >= SET_C) ? FLG_ON : FLG_OFF;
            FLG_ON:  fstate_nx = (level_nx <= CLR_C) ? FLG_OFF : FLG_ON;
            default: fstate_nx = FLG_OFF;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            fstate <= FLG_OFF;
            level  <= '0;
        end else begin
            fstate <= fstate_nx;
            level  <= level_nx;
        end
    end

    // Output decode
    always_comb begin
        flag = (fstate == FLG_ON);
    end

    // R3: level stays within its range
    p_level_cap_r3: assert property (@(posedge clk) disable iff (rst)
        level <= MAX_C);

    // R3: level holds without a step
    p_level_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!step_valid && !clr) |=> $stable(level));

    // R4: the flag only turns on at or above the set threshold
    p_set_thresh_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> level >= SET_C);

    // R4: the flag only turns off at or below the clear threshold
    p_clr_thresh_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(flag) |-> level <= CLR_C);

    // R6: mute empties the integrator and drops the flag
    p_mute_clear_r6: assert property (@(posedge clk) disable iff (rst)
        clr |=> (level == '0 && !flag));

endmodule

// File: rtl/pid_tone_ident.sv
module pid_tone_ident
    import pid_pkg::*;
#(
    parameter int CLK_HZ    = 10_008_000,
    parameter int TICK_DIV  = 100,
    parameter int ST_MHZ    = 117_480,
    parameter int ST_HW_MHZ = 1_100,
    parameter int DU_MHZ    = 274_120,
    parameter int DU_HW_MHZ = 1_150,
    parameter int ST_MAX    = 127,
    parameter int ST_SET    = 96,
    parameter int ST_CLR    = 16,
    parameter int DU_MAX    = 255,
    parameter int DU_SET    = 224,
    parameter int DU_CLR    = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic mute,
    input  logic tone_in,
    output logic stereo_flag,
    output logic dual_flag,
    output logic led_stereo_n,
    output logic led_dual_n
);

    localparam u64_t K_TICK = (u64_t'(CLK_HZ) * 64'd1000) / u64_t'(TICK_DIV);
    localparam int   ST_LO  = int'(ceil_div(K_TICK, u64_t'(ST_MHZ + ST_HW_MHZ)));
    localparam int   ST_HI  = int'(K_TICK / u64_t'(ST_MHZ - ST_HW_MHZ));
    localparam int   DU_LO  = int'(ceil_div(K_TICK, u64_t'(DU_MHZ + DU_HW_MHZ)));
    localparam int   DU_HI  = int'(K_TICK / u64_t'(DU_MHZ - DU_HW_MHZ));
    localparam int   DIV_W  = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    logic            tick;
    logic            rise;
    logic [N_CH-1:0] ch_step, ch_hit, ch_flag;

    // Tick prescaler
    generate
        if (TICK_DIV == 1) begin : g_nodiv
            assign tick = 1'b1;
        end else begin : g_div
            logic [DIV_W-1:0] pc;
            always_ff @(posedge clk) begin
                if (rst) begin
                    pc <= '0;
                end else if (pc == DIV_W'(TICK_DIV - 1)) begin
                    pc <= '0;
                end else begin
                    pc <= pc + 1'b1;
                end
            end
            assign tick = (pc == DIV_W'(TICK_DIV - 1));
        end
    endgenerate

    pid_edge_sync u_sync (
        .clk  (clk),
        .rst  (rst),
        .clr  (mute),
        .din  (tone_in),
        .rise (rise)
    );

    // One meter and integrator per identification tone
    generate
        for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
            localparam int LO  = (ch == CH_DUAL) ? DU_LO  : ST_LO;
            localparam int HI  = (ch == CH_DUAL) ? DU_HI  : ST_HI;
            localparam int MX  = (ch == CH_DUAL) ? DU_MAX : ST_MAX;
            localparam int STH = (ch == CH_DUAL) ? DU_SET : ST_SET;
            localparam int CTH = (ch == CH_DUAL) ? DU_CLR : ST_CLR;

            pid_period_meter #(
                .LO (LO),
                .HI (HI)
            ) u_meter (
                .clk        (clk),
                .rst        (rst),
                .clr        (mute),
                .tick       (tick),
                .rise       (rise),
                .step_valid (ch_step[ch]),
                .step_hit   (ch_hit[ch])
            );

            pid_integrator #(
                .MAX    (MX),
                .SET_TH (STH),
                .CLR_TH (CTH)
            ) u_integ (
                .clk        (clk),
                .rst        (rst),
                .clr        (mute),
                .step_valid (ch_step[ch]),
                .step_hit   (ch_hit[ch]),
                .flag       (ch_flag[ch])
            );
        end
    endgenerate

    // Dual has priority over stereo
    always_comb begin
        dual_flag    = ch_flag[CH_DUAL];
        stereo_flag  = ch_flag[CH_STEREO] & ~ch_flag[CH_DUAL];
        led_stereo_n = ~stereo_flag;
        led_dual_n   = ~dual_flag;
    end

    // R6: mute clears both outputs by the next cycle
    p_mute_flags_r6: assert property (@(posedge clk) disable iff (rst)
        mute |=> (!stereo_flag && !dual_flag));

    // R7: reset leaves both flags low
    p_reset_flags_r7: assert property (@(posedge clk)
        $past(rst) |-> (!stereo_flag && !dual_flag));

    // R3: the two channels' steps come from one shared edge or a timeout
    p_step_hits_exclusive_r1: assert property (@(posedge clk) disable iff (rst)
        !(ch_step[CH_STEREO] && ch_hit[CH_STEREO] && ch_step[CH_DUAL] && ch_hit[CH_DUAL]));

endmodule

// File: tb/sim_pid_tone_ident.sv
module sim_pid_tone_ident;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mute = 1'b0;
    logic tone = 1'b0;
    logic st, du, led_st_n, led_du_n;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    pid_tone_ident #(
        .CLK_HZ   (100_000),
        .TICK_DIV (1),
        .ST_MAX   (15),
        .ST_SET   (8),
        .ST_CLR   (3),
        .DU_MAX   (15),
        .DU_SET   (8),
        .DU_CLR   (3)
    ) u0 (
        .clk          (clk),
        .rst          (rst),
        .mute         (mute),
        .tone_in      (tone),
        .stereo_flag  (st),
        .dual_flag    (du),
        .led_stereo_n (led_st_n),
        .led_dual_n   (led_du_n)
    );

    typedef struct packed {
        logic        rs;
        int unsigned per;
        int unsigned n;
        logic        est;
        logic        edu;
    } vec_t;

    // Stereo window 844..859 cycles, dual window 364..366 cycles
    localparam vec_t VEC [13] = '{
        '{1'b1, 851, 8,  1'b0, 1'b0},  // R1 R4: 7 hits, below set
        '{1'b0, 851, 1,  1'b1, 1'b0},  // R4: 8th hit sets stereo
        '{1'b0, 851, 10, 1'b1, 1'b0},  // R3: saturates
        '{1'b0, 365, 9,  1'b0, 1'b1},  // R5: dual set while stereo state still on
        '{1'b0, 365, 10, 1'b0, 1'b1},
        '{1'b1, 844, 9,  1'b1, 1'b0},  // R1: lower stereo limit inclusive
        '{1'b1, 843, 12, 1'b0, 1'b0},  // R1: below stereo window
        '{1'b1, 859, 9,  1'b1, 1'b0},  // R1: upper stereo limit inclusive
        '{1'b1, 860, 12, 1'b0, 1'b0},  // R1 R2: above stereo window
        '{1'b1, 364, 9,  1'b0, 1'b1},  // R1: lower dual limit
        '{1'b1, 366, 9,  1'b0, 1'b1},  // R1: upper dual limit
        '{1'b1, 363, 12, 1'b0, 1'b0},  // R1: below dual window
        '{1'b1, 367, 12, 1'b0, 1'b0}   // R1 R2: above dual window
    };

    task automatic chk(string req, logic act, logic exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    task automatic chk_out(string req, logic est, logic edu);
        chk(req, st, est, "stereo_flag");
        chk(req, du, edu, "dual_flag");
        chk("R8", led_st_n, ~est, "led_stereo_n");
        chk("R8", led_du_n, ~edu, "led_dual_n");
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic run_tone(int p, int n);
        for (int i = 0; i < n; i++) begin
            tone = 1'b1;
            repeat (p / 2) @(negedge clk);
            tone = 1'b0;
            repeat (p - p / 2) @(negedge clk);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (190_000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk_out("R7", 1'b0, 1'b0);

        // Vector table
        for (int i = 0; i < 13; i++) begin
            if (VEC[i].rs) do_reset();
            run_tone(int'(VEC[i].per), int'(VEC[i].n));
            chk_out($sformatf("R1 R4 R5 row %0d", i), VEC[i].est, VEC[i].edu);
        end

        // R7: reset mid-operation clears, and the first edge after only arms
        do_reset();
        run_tone(365, 12);
        chk_out("R7", 1'b0, 1'b1);
        do_reset();
        chk_out("R7", 1'b0, 1'b0);
        run_tone(365, 8);
        chk_out("R7", 1'b0, 1'b0);
        run_tone(365, 1);
        chk_out("R7", 1'b0, 1'b1);

        // R2 R4: silence decays through timeouts, hysteresis holds above clear
        do_reset();
        run_tone(365, 20);
        repeat (3000) @(negedge clk);
        chk_out("R2 R4 hold", 1'b0, 1'b1);
        repeat (2000) @(negedge clk);
        chk_out("R2 R4 clear", 1'b0, 1'b0);

        // R6: mute clears, blocks detection, re-arms
        do_reset();
        run_tone(851, 12);
        chk_out("R6", 1'b1, 1'b0);
        mute = 1'b1;
        repeat (3) @(negedge clk);
        chk_out("R6 mute", 1'b0, 1'b0);
        run_tone(851, 6);
        chk_out("R6 muted tone", 1'b0, 1'b0);
        mute = 1'b0;
        run_tone(851, 8);
        chk_out("R6 rearm", 1'b0, 1'b0);
        run_tone(851, 1);
        chk_out("R6 restart", 1'b1, 1'b0);

        finish_run();
    end

endmodule